// File: doc/BRIEF.md
# Paged Serial EEPROM Target on a Two-Wire Bus

This block behaves as a byte-addressed serial EEPROM sitting on an I2C bus, so that an on-chip bus master can be exercised against a realistic target without leaving the die. It recognises its device address, takes a two-byte word address, and then stores the bytes the master writes or returns bytes from its array. The logical address is 17 bits wide. The top bit of that address arrives inside the device-address byte, next to the read/write bit. The eight bits below it come from the first word-address byte and the low eight bits from the second.

Writes stay inside a 256-byte page, and the low byte of the address wraps when it passes the end of the page. Reads step through the whole 17-bit space and wrap to zero only after the last address. The slave never drives SDA high. It pulls SDA low through an output-enable pin, and a pull-up outside the block supplies the high level. Both bus lines are sampled through synchronisers on the block clock. The physical array is smaller than the logical space by default. Only the low bits of the address select a byte, so the array repeats across the 17-bit space.

The only data path is the two-wire bus itself. The bus has no valid/ready pairing. The master controls the flow: it acknowledges each read byte to ask for the next one, and it raises a NACK followed by STOP to end the transfer. This slave never stretches the clock.

Top module: `i2c_page_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe` low) and waits for a START.
- R2: The device-address byte matches when its upper seven bits are binary 10100, then `strap_a1`, then the P0 bit in bit 1; bit 0 is the direction (1 = read). A non-matching byte is not acknowledged, and the slave then acknowledges nothing and writes nothing until the next START.
- R3: In a write frame the slave acknowledges the device byte, the high address byte and the low address byte. These load a 17-bit pointer as {P0, high byte, low byte}. Each later data byte is acknowledged and stored at the pointer.
- R4: After each stored data byte only the low 8 pointer bits increment, modulo 256, so page writes wrap to the start of their page.
- R5: Each byte sent on a read comes from the pointer, MSB first. The pointer then increments over all 17 bits and wraps from 0x1FFFF to 0. The P0 bit of a read device byte is ignored.
- R6: A read continues with the next byte for as long as the master acknowledges, including across page boundaries. A NACK ends the read, and the slave leaves SDA released.
- R7: A current-address read (read device byte with no address phase) starts from wherever the previous frame left the pointer.
- R8: A START or repeated START at any bit position restarts the framing at the device-address byte. A frame interrupted this way keeps the bytes already stored.
- R9: A STOP directly after the two address bytes loads the pointer and leaves the array unchanged, which sets up a later current-address read.
- R10: `sda_oe` changes only while the synchronised SCL is low. START and STOP are recognised as SDA falling and rising edges while SCL is high.
- R11: The array holds 2^MEM_AW bytes and is indexed by the low MEM_AW pointer bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a1 | input | 1 | Strap value compared with device-address bit 2 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest cases to reach from the bus are pointer wrap-around and frames cut off partway through a byte. To reach the wrap, the bench sends an address-only frame of all ones (P0 set, both address bytes 0xFF) and then performs a two-byte current-address read, whose second byte must come from location zero. To cut a frame short, the bench clocks out only a few bits of a byte, issues a repeated START, and then proves through later reads that the earlier bytes survived and the pointer stood where the requirements place it. The whole reduced array is first filled by page writes with an arithmetic pattern, then read back in one sequential read that crosses every page boundary.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;
  localparam int WORD_AW = 17;           // logical byte address width
  localparam int PAGE_AW = 8;            // bits that roll within a page on writes
  localparam logic [4:0] DEV_FIXED = 5'b10100;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_hit,
  output logic stop_hit
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edge with the clock high on both samples marks a bus condition
  assign start_hit = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_hit  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/word_pointer.sv
module word_pointer import eeprom_slv_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [WORD_AW-1:0] ld_val,
  input  logic               inc_page,
  input  logic               inc_lin,
  output logic [WORD_AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ld_en) begin
      ptr <= ld_val;
    end else if (inc_page) begin
      ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
    end else if (inc_lin) begin
      ptr <= ptr + 1'b1;
    end
  end

  // R4: a write step never leaves the current page
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_page |=> ptr[WORD_AW-1:PAGE_AW] == $past(ptr[WORD_AW-1:PAGE_AW]));

  // R5: a read step from the last address lands on zero
  assert_lin_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_lin && !ld_en && !inc_page && ptr == {WORD_AW{1'b1}}) |=> ptr == '0);
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl import eeprom_slv_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_hit,
  input  logic               stop_hit,
  input  logic               strap_a1,
  input  logic [7:0]         rd_byte,
  output logic               sda_oe,
  output logic               wr_en,
  output logic [7:0]         wr_byte,
  output logic               ld_en,
  output logic [WORD_AW-1:0] ld_val,
  output logic               inc_page,
  output logic               inc_lin
);
  phase_t     ph;
  logic [3:0] nbit;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic [7:0] hi_q;
  logic       ack_slot;
  logic       hold_p0;
  logic       rd_mode;
  logic       m_ack;
  logic       rx_phase;
  logic       byte_done;
  logic       dev_hit;

  assign rx_phase  = ph inside {PH_DEV, PH_AHI, PH_ALO, PH_WDAT};
  assign byte_done = scl_fall & ~ack_slot & (nbit == 4'd8);
  assign dev_hit   = (shreg[7:3] == DEV_FIXED) && (shreg[2] == strap_a1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      nbit     <= '0;
      shreg    <= '0;
      txreg    <= '0;
      hi_q     <= '0;
      ack_slot <= 1'b0;
      hold_p0  <= 1'b0;
      rd_mode  <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_byte  <= '0;
      ld_en    <= 1'b0;
      ld_val   <= '0;
      inc_page <= 1'b0;
      inc_lin  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      ld_en    <= 1'b0;
      inc_page <= 1'b0;
      inc_lin  <= 1'b0;
      if (start_hit) begin
        ph       <= PH_DEV;
        nbit     <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_hit) begin
        ph       <= PH_IDLE;
        nbit     <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (rx_phase) begin
        if (scl_rise && !ack_slot && nbit < 4'd8) begin
          shreg <= {shreg[6:0], sda_s};
          nbit  <= nbit + 1'b1;
        end else if (byte_done) begin
          case (ph)
            PH_DEV: begin
              if (dev_hit) begin
                sda_oe   <= 1'b1;
                ack_slot <= 1'b1;
                rd_mode  <= shreg[0];
                if (!shreg[0]) hold_p0 <= shreg[1];
              end else begin
                ph <= PH_SKIP;
              end
            end
            PH_AHI: begin
              hi_q     <= shreg;
              sda_oe   <= 1'b1;
              ack_slot <= 1'b1;
            end
            PH_ALO: begin
              ld_val   <= {hold_p0, hi_q, shreg};
              ld_en    <= 1'b1;
              sda_oe   <= 1'b1;
              ack_slot <= 1'b1;
            end
            default: begin
              wr_byte  <= shreg;
              wr_en    <= 1'b1;
              inc_page <= 1'b1;
              sda_oe   <= 1'b1;
              ack_slot <= 1'b1;
            end
          endcase
        end else if (scl_fall && ack_slot) begin
          ack_slot <= 1'b0;
          nbit     <= '0;
          sda_oe   <= 1'b0;
          case (ph)
            PH_DEV: begin
              if (rd_mode) begin
                ph     <= PH_RDAT;
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                ph <= PH_AHI;
              end
            end
            PH_AHI:  ph <= PH_ALO;
            PH_ALO:  ph <= PH_WDAT;
            default: ph <= PH_WDAT;
          endcase
        end
      end else if (ph == PH_RDAT) begin
        if (scl_rise) begin
          if (ack_slot) m_ack <= ~sda_s;
          else          nbit  <= nbit + 1'b1;
        end else if (scl_fall) begin
          if (ack_slot) begin
            ack_slot <= 1'b0;
            if (m_ack) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              nbit   <= '0;
            end else begin
              ph <= PH_SKIP;
            end
          end else if (nbit == 4'd8) begin
            sda_oe   <= 1'b0;
            ack_slot <= 1'b1;
            inc_lin  <= 1'b1;
          end else begin
            txreg  <= {txreg[6:0], 1'b0};
            sda_oe <= ~txreg[6];
          end
        end
      end
    end
  end

  // R10: the slave starts pulling SDA only while the clock is low
  assert_oe_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2: after a mismatch the line stays released
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SKIP) |-> !sda_oe);

  // R6: the master's acknowledge slot is never driven by the slave
  assert_mack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RDAT && ack_slot) |-> !sda_oe);

  // R3: array writes come only from the data phase of a write frame
  assert_we_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ph) == PH_WDAT);
endmodule

// File: rtl/i2c_page_eeprom_slave.sv
module i2c_page_eeprom_slave import eeprom_slv_pkg::*; #(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_a1,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_hit, stop_hit;
  logic wr_en, ld_en, inc_page, inc_lin;
  logic [7:0] wr_byte, rd_byte;
  logic [WORD_AW-1:0] ld_val, ptr;

  bus_cond_detect #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_hit(start_hit), .stop_hit(stop_hit)
  );

  frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_hit(start_hit), .stop_hit(stop_hit), .strap_a1(strap_a1),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_en(wr_en), .wr_byte(wr_byte),
    .ld_en(ld_en), .ld_val(ld_val), .inc_page(inc_page), .inc_lin(inc_lin)
  );

  word_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
    .inc_page(inc_page), .inc_lin(inc_lin), .ptr(ptr)
  );

  // R11: the low pointer bits select the physical byte
  byte_store #(.AW(MEM_AW)) u_store (
    .clk(clk), .we(wr_en), .waddr(ptr[MEM_AW-1:0]), .wdata(wr_byte),
    .raddr(ptr[MEM_AW-1:0]), .rdata(rd_byte)
  );
endmodule

// File: tb/test_i2c_page_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_page_eeprom_slave;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   n_chk = 0;
  int   n_err = 0;
  int   r10_viol = 0;
  bit   done = 1'b0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_page_eeprom_slave #(.MEM_AW(AW)) i_i2c_page_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .strap_a1(1'b1),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R10 monitor: the slave output must not move while SCL stays high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_oe !== prev_oe) r10_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] dev(input logic p0, input logic rd);
    return {5'b10100, 1'b1, p0, rd};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(2);
    b = sda_line; tick(H - 2);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic addr_frame(input logic [16:0] a, input bit stop_after);
    logic ack;
    bus_start();
    send_byte(dev(a[16], 1'b0), ack);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    if (stop_after) bus_stop();
  endtask

  task automatic read_run(input int n, input int base, input string tag);
    logic [7:0] v;
    logic ack;
    send_byte(dev(1'b0, 1'b1), ack);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk(tag, v, model[(base + k) % DEPTH]);
    end
    bus_stop();
  endtask

  task automatic rand_read(input int a, input int n, input string tag);
    addr_frame(17'(a), 1'b0);
    bus_start();
    read_run(n, a, tag);
  endtask

  task automatic cur_read(input int base, input int n, input string tag);
    bus_start();
    read_run(n, base, tag);
  endtask

  initial begin
    logic ack;
    int acks;
    tick(4);
    chk("R1 released during reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    tick(10);
    chk("R1 released after reset", sda_oe, 1'b0);

    // R3 R4: fill every page with an arithmetic pattern
    for (int pg = 0; pg < DEPTH / 256; pg++) begin
      acks = 0;
      bus_start();
      send_byte(dev(1'b0, 1'b0), ack); acks += int'(ack);
      send_byte(8'(pg), ack);          acks += int'(ack);
      send_byte(8'h00, ack);           acks += int'(ack);
      for (int k = 0; k < 256; k++) begin
        model[pg * 256 + k] = pat(pg * 256 + k);
        send_byte(pat(pg * 256 + k), ack);
        acks += int'(ack);
      end
      bus_stop();
      chk("R3 page fill acknowledges", acks, 259);
    end

    // R6 R7: one sequential read over the whole array
    rand_read(0, DEPTH, "R6 sequential sweep");
    chk("R6 released after NACK", sda_oe, 1'b0);

    // R4: three bytes from offset 0xFE of page 1 wrap to the page start
    addr_frame(17'h001FE, 1'b0);
    send_byte(8'hA1, ack); model[9'h1FE] = 8'hA1;
    send_byte(8'hB2, ack); model[9'h1FF] = 8'hB2;
    send_byte(8'hC3, ack); model[9'h100] = 8'hC3;
    bus_stop();
    rand_read(9'h1FE, 2, "R4 bytes before wrap");
    rand_read(9'h100, 1, "R4 byte wrapped to page start");
    cur_read(9'h101, 1, "R7 current read after random read");

    // R9: address-only frame loads the pointer without writing
    addr_frame(17'h00040, 1'b1);
    cur_read(9'h040, 1, "R9 address-only then current read");
    cur_read(9'h041, 1, "R5 pointer advanced by one");

    // R5 R11: wrap from the last logical address to zero
    addr_frame(17'h1FFFF, 1'b1);
    cur_read(9'h1FF, 2, "R5 wrap from top address");

    // R2: wrong strap bit and wrong fixed bits are ignored
    bus_start();
    send_byte({5'b10100, 1'b0, 1'b0, 1'b0}, ack);
    chk("R2 wrong strap not acknowledged", ack, 1'b0);
    send_byte(8'h00, ack);
    chk("R2 rest of frame ignored", ack, 1'b0);
    send_byte(8'h10, ack);
    send_byte(8'h5A, ack);
    chk("R2 data after mismatch ignored", ack, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'hB2, ack);
    chk("R2 wrong fixed bits not acknowledged", ack, 1'b0);
    bus_stop();
    rand_read(9'h010, 1, "R2 array untouched by ignored frame");

    // R8: restart in the middle of the device byte
    bus_start();
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    addr_frame(17'h00020, 1'b0);
    send_byte(8'h77, ack); model[9'h020] = 8'h77;
    bus_stop();
    rand_read(9'h020, 1, "R8 frame after partial byte");

    // R8: restart in the middle of a data byte, then read on
    addr_frame(17'h00021, 1'b0);
    send_byte(8'h99, ack); model[9'h021] = 8'h99;
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    cur_read(9'h022, 1, "R8 read after cut data byte");
    rand_read(9'h021, 1, "R8 byte before cut kept");

    chk("R10 output steady while SCL high", r10_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule